// File: doc/BRIEF.md
# Key-Protected Windowed Watchdog Timer

This block is a down-counting supervision timer that software has to service on a regular basis. After it is started, it counts down one step on each millisecond tick. The tick comes from outside the block as a single-cycle enable pulse. If the count reaches zero, the block raises a reset request. Software services the timer by writing a reload key. Two further keys unlock the configuration registers and start the counter. A refresh that comes too early, while the count is still above a programmed window value, is treated as a fault and raises the reset request at once.

An optional early-warning flag rises when the count reaches a programmed threshold. This gives software a chance to act before expiry. The count freezes while a debug-halt input is high. A compile-time parameter picks one of two variants, and the variants differ in three places:

- **Sleep behaviour:** the system variant always freezes in sleep. The independent variant follows a configuration bit and either freezes or keeps counting.
- **Reset output:** the system variant can route its expiry to a global or a local reset output. The independent variant always uses the global output.
- **Editing limits while running:** the system variant freezes both timeout and window once running. The independent variant only lets the timeout be lowered.

Every accepted write holds a busy flag for a fixed number of cycles. Writes that arrive during that time are dropped.

Top module: `wdt_guard`

## Requirements
- R1: Register word addresses are fixed: key 0, timeout 1, window 2, early threshold 3, control 4, status 5, count 6 (read only).
  - Writes to addresses 1 to 5 take effect only while the block is unlocked.
  - Writing 0x6969 to the key address unlocks the block.
  - Writing any other value that is not one of the three keys locks it again and has no other effect.
- R2: Writing 0x3C3C to the key address (no unlock needed) loads the count with the timeout and starts the counter. Once started, nothing except rst_n stops it, including further key writes.
- R3: While the counter is running and not held, each tick_i cycle lowers the count by one. When the count reaches zero, the reset request rises. The request stays high until rst_n, and the count stops.
- R4: Writing 0x5A5A to the key address (no unlock needed) while running reloads the count with the current timeout.
- R5: A timeout write of 0 is ignored. A timeout written while running leaves the count untouched until the next reload.
- R6: In the independent variant (SYSTEM_VARIANT=0), a timeout write while running is accepted only if it is lower than the present timeout.
- R7: In the system variant (SYSTEM_VARIANT=1), timeout and window writes are ignored while running.
- R8: Control bit 0 enables the early warning. When it is set and a tick brings the count to the early threshold, status bit 1 and irq_o rise. Writing status with bit 1 set clears the flag.
- R9: The count holds while dbg_halt_i is high. It also holds while sleep_i is high, except in the independent variant with control bit 1 set.
- R10: On expiry, rst_global_o rises unless the system variant has control bit 2 set, in which case rst_local_o rises instead. The two outputs are never high together.
- R11: Each accepted write raises busy_o (also status bit 0) for BUSY_CYCLES cycles. Any write arriving while busy is dropped.
- R12: A reload key arriving while the window value is non-zero and the count is above it raises the reset request at once. A count equal to the window is a valid reload, and a window of 0 disables the check.
- R13: The status word reads busy in bit 0, early flag in bit 1, running in bit 2 and unlocked in bit 3. The count address reads the live count, which is 0 before start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Millisecond tick enable pulse |
| dbg_halt_i | input | 1 | Debug halt, freezes the count |
| sleep_i | input | 1 | System sleep indication |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write word address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read word address |
| rd_data_o | output | 32 | Register read data (combinational) |
| busy_o | output | 1 | Write still being absorbed |
| irq_o | output | 1 | Early-warning interrupt |
| rst_global_o | output | 1 | Global reset request |
| rst_local_o | output | 1 | Local reset request (system variant) |

## Verification
The bench targets the following corner cases. Each item names the faulty behaviour it would catch.

- **Lock and busy rules:** the bench drops a write issued during the busy period and locks the block with a stray key value. A design that ignored either rule would let the timeout change.
- **Refresh at the window edge:** the bench refreshes exactly at the window boundary and then once more far above it. A design with an off-by-one in the comparison would reset on the legal refresh or miss the early one.
- **Timeout edits while running:** the bench raises the timeout, lowers it, and writes it on the system variant. A design that reloaded the count at once, allowed an increase, or let a frozen register change would show a wrong count.
- **Hold conditions:** the bench runs the debug and sleep hold combinations on both variants.
- **Routing and stickiness:** the bench exposes a wrong reset route and checks that the early flag is set on the exact tick and not lost before the clear.

// File: rtl/wdt_guard_pkg.sv
// Shared constants and types for the key-protected windowed watchdog.
// Assumes a 32-bit write bus with word addresses and 16-bit counter fields.
package wdt_guard_pkg;

    localparam int CNT_W  = 16;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;

    localparam logic [CNT_W-1:0] KEY_UNLOCK = 16'h6969;
    localparam logic [CNT_W-1:0] KEY_START  = 16'h3C3C;
    localparam logic [CNT_W-1:0] KEY_FEED   = 16'h5A5A;

    typedef enum logic [ADDR_W-1:0] {
        REG_KEY     = 3'd0,
        REG_TIMEOUT = 3'd1,
        REG_WINDOW  = 3'd2,
        REG_EARLY   = 3'd3,
        REG_CTRL    = 3'd4,
        REG_STATUS  = 3'd5,
        REG_COUNT   = 3'd6
    } reg_idx_e;

    typedef struct packed {
        logic local_sel;   // bit 2: route expiry to local reset (system variant)
        logic sleep_run;   // bit 1: keep counting in sleep (independent variant)
        logic early_en;    // bit 0: early-warning enable
    } ctrl_t;

endpackage

// File: rtl/wdt_guard_regs.sv
// Register write side of the watchdog: key decoding, unlock state,
// write absorption (busy) and configuration storage.
// Assumes BUSY_CYCLES >= 1 and RESET_TIMEOUT in 1..65535.
module wdt_guard_regs
    import wdt_guard_pkg::*;
#(
    parameter int               SYSTEM_VARIANT = 0,
    parameter int               BUSY_CYCLES    = 2,
    parameter logic [CNT_W-1:0] RESET_TIMEOUT  = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              running_i,
    output logic [CNT_W-1:0]  timeout_o,
    output logic [CNT_W-1:0]  window_o,
    output logic [CNT_W-1:0]  thresh_o,
    output ctrl_t             ctrl_o,
    output logic              unlocked_o,
    output logic              busy_o,
    output logic              start_p_o,
    output logic              feed_p_o,
    output logic              irq_clr_p_o
);

    localparam int BUSY_W = (BUSY_CYCLES < 1) ? 1 : $clog2(BUSY_CYCLES + 1);

    logic [BUSY_W-1:0] busy_cnt;
    logic              accept;
    logic              key_wr;
    logic              cfg_wr;
    logic              upper_zero;
    logic [CNT_W-1:0]  val;
    logic              tmo_allow;
    logic              win_allow;

    assign accept     = wr_en_i && (busy_cnt == '0);
    assign upper_zero = (wr_data_i[DATA_W-1:CNT_W] == '0);
    assign val        = wr_data_i[CNT_W-1:0];
    assign key_wr     = accept && (wr_addr_i == REG_KEY);
    assign cfg_wr     = accept && unlocked_o;

    // Variant-specific edit permission for timeout and window while running.
    generate
        if (SYSTEM_VARIANT != 0) begin : g_sys_lock
            assign tmo_allow = (val != '0) && !running_i;
            assign win_allow = !running_i;
        end else begin : g_ind_lock
            assign tmo_allow = (val != '0) && (!running_i || (val < timeout_o));
            assign win_allow = 1'b1;
        end
    endgenerate

    // Key pulses toward the counter; only exact values with clear upper bits count.
    assign start_p_o   = key_wr && upper_zero && (val == KEY_START);
    assign feed_p_o    = key_wr && upper_zero && (val == KEY_FEED);
    assign irq_clr_p_o = cfg_wr && (wr_addr_i == REG_STATUS) && wr_data_i[1];
    assign busy_o      = (busy_cnt != '0);

    // Busy counter: reloaded by every accepted write, counts down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (accept) begin
            busy_cnt <= BUSY_W'(BUSY_CYCLES);
        end else if (busy_cnt != '0) begin
            busy_cnt <= busy_cnt - 1'b1;
        end
    end

    // Unlock state: set by the unlock key, cleared by any unknown key value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked_o <= 1'b0;
        end else if (key_wr) begin
            if (upper_zero && (val == KEY_UNLOCK)) begin
                unlocked_o <= 1'b1;
            end else if (!(upper_zero && ((val == KEY_START) || (val == KEY_FEED)))) begin
                unlocked_o <= 1'b0;
            end
        end
    end

    // Configuration storage, written only while unlocked and within the variant's rules.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout_o <= RESET_TIMEOUT;
            window_o  <= '0;
            thresh_o  <= '0;
            ctrl_o    <= '0;
        end else if (cfg_wr) begin
            case (wr_addr_i)
                REG_TIMEOUT: if (tmo_allow) timeout_o <= val;
                REG_WINDOW:  if (win_allow) window_o  <= val;
                REG_EARLY:   thresh_o <= val;
                REG_CTRL:    ctrl_o   <= ctrl_t'(wr_data_i[2:0]);
                default:     ;
            endcase
        end
    end

endmodule

// File: rtl/wdt_guard_count.sv
// Down-counter core: start, reload with window check, tick decrement with
// hold, expiry latch and early-warning flag.
// Assumes the timeout is non-zero whenever the start key arrives.
module wdt_guard_count
    import wdt_guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             hold_i,
    input  logic             start_p_i,
    input  logic             feed_p_i,
    input  logic [CNT_W-1:0] timeout_i,
    input  logic [CNT_W-1:0] window_i,
    input  logic [CNT_W-1:0] thresh_i,
    input  logic             early_en_i,
    input  logic             irq_clr_p_i,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o,
    output logic             expired_o,
    output logic             irq_flag_o
);

    logic active;
    logic step;
    logic early_feed;

    assign active     = running_o && !expired_o;
    assign early_feed = (window_i != '0) && (count_o > window_i);
    assign step       = active && !feed_p_i && tick_i && !hold_i;

    // Count, run state and expiry latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o   <= '0;
            running_o <= 1'b0;
            expired_o <= 1'b0;
        end else if (start_p_i && !running_o) begin
            running_o <= 1'b1;
            count_o   <= timeout_i;
        end else if (active && feed_p_i) begin
            if (early_feed) begin
                expired_o <= 1'b1;
            end else begin
                count_o <= timeout_i;
            end
        end else if (step) begin
            count_o <= count_o - 1'b1;
            if (count_o == CNT_W'(1)) begin
                expired_o <= 1'b1;
            end
        end
    end

    // Early-warning flag: set on the tick that lands on the threshold, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_flag_o <= 1'b0;
        end else if (step && early_en_i && ((count_o - 1'b1) == thresh_i)) begin
            irq_flag_o <= 1'b1;
        end else if (irq_clr_p_i) begin
            irq_flag_o <= 1'b0;
        end
    end

endmodule

// File: rtl/wdt_guard_route.sv
// Expiry routing: maps the expiry latch to the global or local reset request.
// The independent variant always uses the global request.
module wdt_guard_route #(
    parameter int SYSTEM_VARIANT = 0
) (
    input  logic expired_i,
    input  logic local_sel_i,
    output logic rst_global_o,
    output logic rst_local_o
);

    logic use_local;

    // Local routing exists only in the system variant.
    assign use_local    = (SYSTEM_VARIANT != 0) && local_sel_i;
    assign rst_global_o = expired_i && !use_local;
    assign rst_local_o  = expired_i && use_local;

endmodule

// File: rtl/wdt_guard.sv
// Top of the key-protected windowed watchdog. Joins the register block,
// the counter core and the reset routing, forms the hold condition and
// provides the combinational read port.
// Assumes tick_i is a single-cycle enable from an external tick generator.
module wdt_guard
    import wdt_guard_pkg::*;
#(
    parameter int               SYSTEM_VARIANT = 0,
    parameter int               BUSY_CYCLES    = 2,
    parameter logic [CNT_W-1:0] RESET_TIMEOUT  = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              dbg_halt_i,
    input  logic              sleep_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              busy_o,
    output logic              irq_o,
    output logic              rst_global_o,
    output logic              rst_local_o
);

    logic [CNT_W-1:0] timeout_q;
    logic [CNT_W-1:0] window_q;
    logic [CNT_W-1:0] thresh_q;
    ctrl_t            ctrl_q;
    logic             unlocked;
    logic             start_p;
    logic             feed_p;
    logic             irq_clr_p;
    logic [CNT_W-1:0] count;
    logic             running;
    logic             expired;
    logic             irq_flag;
    logic             hold;

    wdt_guard_regs #(
        .SYSTEM_VARIANT (SYSTEM_VARIANT),
        .BUSY_CYCLES    (BUSY_CYCLES),
        .RESET_TIMEOUT  (RESET_TIMEOUT)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .running_i   (running),
        .timeout_o   (timeout_q),
        .window_o    (window_q),
        .thresh_o    (thresh_q),
        .ctrl_o      (ctrl_q),
        .unlocked_o  (unlocked),
        .busy_o      (busy_o),
        .start_p_o   (start_p),
        .feed_p_o    (feed_p),
        .irq_clr_p_o (irq_clr_p)
    );

    // Hold: debug always; sleep unless the independent variant is told to run.
    assign hold = dbg_halt_i ||
                  (sleep_i && ((SYSTEM_VARIANT != 0) || !ctrl_q.sleep_run));

    wdt_guard_count u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .hold_i      (hold),
        .start_p_i   (start_p),
        .feed_p_i    (feed_p),
        .timeout_i   (timeout_q),
        .window_i    (window_q),
        .thresh_i    (thresh_q),
        .early_en_i  (ctrl_q.early_en),
        .irq_clr_p_i (irq_clr_p),
        .count_o     (count),
        .running_o   (running),
        .expired_o   (expired),
        .irq_flag_o  (irq_flag)
    );

    wdt_guard_route #(
        .SYSTEM_VARIANT (SYSTEM_VARIANT)
    ) u_route (
        .expired_i    (expired),
        .local_sel_i  (ctrl_q.local_sel),
        .rst_global_o (rst_global_o),
        .rst_local_o  (rst_local_o)
    );

    assign irq_o = irq_flag;

    // Read mux over the register words.
    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            REG_TIMEOUT: rd_data_o = DATA_W'(timeout_q);
            REG_WINDOW:  rd_data_o = DATA_W'(window_q);
            REG_EARLY:   rd_data_o = DATA_W'(thresh_q);
            REG_CTRL:    rd_data_o = DATA_W'(ctrl_q);
            REG_STATUS:  rd_data_o = DATA_W'({unlocked, running, irq_flag, busy_o});
            REG_COUNT:   rd_data_o = DATA_W'(count);
            default:     rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/wdt_guard_chk.sv
// Assertion checker for wdt_guard, attached by bind below.
module wdt_guard_chk
    import wdt_guard_pkg::*;
#(
    parameter int SYSTEM_VARIANT = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] timeout_q,
    input logic [CNT_W-1:0] window_q,
    input logic             hold,
    input logic             feed_p,
    input logic             busy_o,
    input logic             wr_en_i,
    input logic             rst_global_o,
    input logic             rst_local_o
);

    // R10
    rst_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_global_o && rst_local_o));

    // R2
    run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);

    // R3
    rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_global_o || rst_local_o) |=> (rst_global_o || rst_local_o));

    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && hold && !feed_p) |=> $stable(count));

    // R11
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && wr_en_i) |=> ($stable(timeout_q) && $stable(window_q)));

    generate
        if (SYSTEM_VARIANT != 0) begin : g_sys
            // R7
            frozen_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
                running |=> ($stable(timeout_q) && $stable(window_q)));
        end else begin : g_ind
            // R6
            tmo_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
                running |=> (timeout_q <= $past(timeout_q)));
        end
    endgenerate

endmodule

bind wdt_guard wdt_guard_chk #(
    .SYSTEM_VARIANT (SYSTEM_VARIANT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .running      (running),
    .count        (count),
    .timeout_q    (timeout_q),
    .window_q     (window_q),
    .hold         (hold),
    .feed_p       (feed_p),
    .busy_o       (busy_o),
    .wr_en_i      (wr_en_i),
    .rst_global_o (rst_global_o),
    .rst_local_o  (rst_local_o)
);

// File: tb/wdt_guard_test.sv
// Directed bench: uut is the independent variant, uut_sys the system variant.
module wdt_guard_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] A_KEY = 3'd0, A_TMO = 3'd1, A_WIN = 3'd2, A_EARLY = 3'd3,
                           A_CTRL = 3'd4, A_STAT = 3'd5, A_CNT = 3'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        dbg = 1'b0;
    logic        slp = 1'b0;
    logic        wen_a = 1'b0;
    logic        wen_b = 1'b0;
    logic [2:0]  waddr = '0;
    logic [31:0] wdata = '0;
    logic [2:0]  raddr = '0;
    logic [31:0] rd_a, rd_b;
    logic        busy_a, busy_b, irq_a, irq_b, glob_a, glob_b, loc_a, loc_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_guard #(.SYSTEM_VARIANT(0)) uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .dbg_halt_i(dbg), .sleep_i(slp),
        .wr_en_i(wen_a), .wr_addr_i(waddr), .wr_data_i(wdata), .rd_addr_i(raddr),
        .rd_data_o(rd_a), .busy_o(busy_a), .irq_o(irq_a),
        .rst_global_o(glob_a), .rst_local_o(loc_a)
    );

    wdt_guard #(.SYSTEM_VARIANT(1)) uut_sys (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .dbg_halt_i(dbg), .sleep_i(slp),
        .wr_en_i(wen_b), .wr_addr_i(waddr), .wr_data_i(wdata), .rd_addr_i(raddr),
        .rd_data_o(rd_b), .busy_o(busy_b), .irq_o(irq_b),
        .rst_global_o(glob_b), .rst_local_o(loc_b)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic raw_wr(input bit sel, input logic [2:0] a, input int d);
        waddr = a;
        wdata = d;
        if (sel) wen_b = 1'b1; else wen_a = 1'b1;
        @(negedge clk);
        wen_a = 1'b0;
        wen_b = 1'b0;
    endtask

    task automatic wr(input bit sel, input logic [2:0] a, input int d);
        while (sel ? busy_b : busy_a) @(negedge clk);
        raw_wr(sel, a, d);
    endtask

    task automatic rd(input bit sel, input logic [2:0] a, output int v);
        raddr = a;
        #1;
        v = sel ? rd_b : rd_a;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic t_reset_state();
        int v;
        chk("R10 global after reset", glob_a, 0);
        chk("R10 local after reset", loc_a, 0);
        chk("R8 irq after reset", irq_a, 0);
        chk("R11 busy after reset", busy_a, 0);
        rd(0, A_CNT, v);  chk("R13 count after reset", v, 0);
        rd(0, A_STAT, v); chk("R13 status after reset", v, 0);
        rd(0, A_TMO, v);  chk("R1 timeout reset value", v, 65535);
    endtask

    task automatic t_lock_busy();
        int v;
        wr(0, A_TMO, 5);
        rd(0, A_TMO, v); chk("R1 locked write ignored", v, 65535);
        wr(0, A_KEY, 32'h6969);
        wr(0, A_TMO, 10);
        chk("R11 busy after write", busy_a, 1);
        raw_wr(0, A_TMO, 3);
        wr(0, A_TMO, 0);
        rd(0, A_TMO, v); chk("R11 busy drop and R5 zero ignored", v, 10);
        rd(0, A_STAT, v); chk("R13 unlocked bit", (v >> 3) & 1, 1);
        wr(0, A_KEY, 32'h1234);
        wr(0, A_TMO, 7);
        rd(0, A_TMO, v); chk("R1 bad key relocks", v, 10);
        rd(0, A_STAT, v); chk("R1 unlocked bit cleared", (v >> 3) & 1, 0);
    endtask

    task automatic t_start_count();
        int v;
        wr(0, A_KEY, 32'h3C3C);
        rd(0, A_CNT, v); chk("R2 start loads count", v, 10);
        rd(0, A_STAT, v); chk("R13 running bit", (v >> 2) & 1, 1);
        ticks(3);
        rd(0, A_CNT, v); chk("R3 decrement per tick", v, 7);
        wr(0, A_KEY, 0);
        ticks(1);
        rd(0, A_CNT, v); chk("R2 cannot be stopped", v, 6);
    endtask

    task automatic t_ind_timeout();
        int v;
        wr(0, A_KEY, 32'h6969);
        wr(0, A_TMO, 20);
        rd(0, A_TMO, v); chk("R6 raise rejected", v, 10);
        wr(0, A_TMO, 8);
        rd(0, A_TMO, v); chk("R6 lower accepted", v, 8);
        rd(0, A_CNT, v); chk("R5 count untouched", v, 6);
        wr(0, A_KEY, 32'h5A5A);
        rd(0, A_CNT, v); chk("R4 reload uses new timeout", v, 8);
    endtask

    task automatic t_hold();
        int v;
        dbg = 1'b1; ticks(2); dbg = 1'b0;
        rd(0, A_CNT, v); chk("R9 debug hold", v, 8);
        slp = 1'b1; ticks(1);
        rd(0, A_CNT, v); chk("R9 sleep hold default", v, 8);
        wr(0, A_CTRL, 2); ticks(1);
        rd(0, A_CNT, v); chk("R9 sleep run bit", v, 7);
        slp = 1'b0;
    endtask

    task automatic t_early();
        int v;
        wr(0, A_EARLY, 5);
        wr(0, A_CTRL, 3);
        ticks(1); chk("R8 irq before threshold", irq_a, 0);
        ticks(1); chk("R8 irq at threshold", irq_a, 1);
        ticks(1); chk("R8 irq sticky", irq_a, 1);
        rd(0, A_STAT, v); chk("R13 irq status bit", (v >> 1) & 1, 1);
        wr(0, A_STAT, 2); chk("R8 irq cleared", irq_a, 0);
    endtask

    task automatic t_expire();
        int v;
        ticks(3);
        chk("R3 no reset at count 1", glob_a, 0);
        ticks(1);
        chk("R3 R10 global on expiry", glob_a, 1);
        chk("R10 no local in independent", loc_a, 0);
        wr(0, A_KEY, 32'h5A5A); ticks(2);
        chk("R3 reset sticky", glob_a, 1);
        rd(0, A_CNT, v); chk("R3 count stays zero", v, 0);
    endtask

    task automatic t_sys_window();
        int v;
        wr(1, A_KEY, 32'h6969);
        wr(1, A_TMO, 10);
        wr(1, A_WIN, 4);
        wr(1, A_CTRL, 6);
        wr(1, A_KEY, 32'h3C3C);
        wr(1, A_TMO, 5);
        rd(1, A_TMO, v); chk("R7 timeout frozen", v, 10);
        wr(1, A_WIN, 2);
        rd(1, A_WIN, v); chk("R7 window frozen", v, 4);
        slp = 1'b1; ticks(1); slp = 1'b0;
        rd(1, A_CNT, v); chk("R9 system sleep hold", v, 10);
        ticks(6);
        rd(1, A_CNT, v); chk("R3 system count", v, 4);
        wr(1, A_KEY, 32'h5A5A);
        rd(1, A_CNT, v); chk("R12 refresh at window edge", v, 10);
        chk("R12 no reset at window edge", loc_b | glob_b, 0);
        wr(1, A_KEY, 32'h5A5A);
        chk("R12 R10 early refresh local reset", loc_b, 1);
        chk("R10 global stays low", glob_b, 0);
    endtask

    task automatic t_window_off();
        int v;
        wr(1, A_KEY, 32'h6969);
        wr(1, A_TMO, 10);
        wr(1, A_KEY, 32'h3C3C);
        ticks(1);
        wr(1, A_KEY, 32'h5A5A);
        rd(1, A_CNT, v); chk("R12 window zero disables", v, 10);
        chk("R12 no reset with window zero", glob_b | loc_b, 0);
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_lock_busy();
        t_start_count();
        t_ind_timeout();
        t_hold();
        t_early();
        t_expire();
        do_reset();
        t_sys_window();
        do_reset();
        t_window_off();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule